// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block merges a set of nonmaskable trap requests and a larger set of maskable peripheral interrupt requests into a single request line toward a CPU. Along with the request it presents the vector number of the winning source and the program-memory address of that source's entry in the vector table. Each maskable source carries its own enable bit and a 3-bit priority level. Arbitration works in two tiers: the programmed level decides first, and the position in the vector table breaks ties. Traps skip the level comparison and outrank every maskable source.

The CPU takes a presented vector with a one-cycle take strobe. The block answers with a one-cycle acknowledge and clears that source's pending flag. It then withholds any further request until the CPU signals return from the handler. A single table-select input moves every lookup to an alternate table. That table has the same layout as the primary one and sits directly after it in program memory. The path from request to presented vector always takes the same number of clock cycles.

Top module: `prio_vic`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `int_req` and `int_ack` are 0, `vec_num` and `vec_addr` are 0, and every pending flag is cleared.
- R2: A one-cycle pulse on `trap_set[t]` or `irq_set[i]` sets that source's pending flag. The flag stays set until that source is taken. If a set pulse arrives on the same edge as that source's take, the flag stays set.
- R3: A maskable source `i` may win only if it is pending, `irq_en[i]` is 1, and its level `irq_lvl[3*i+2:3*i]` is nonzero and strictly greater than `cpu_lvl`. A source that fails this test keeps its pending flag.
- R4: Among eligible maskable sources, the highest level wins. At equal levels the lower source index wins.
- R5: Any pending trap wins over every maskable source, whatever the value of `cpu_lvl`. Among traps the lowest index wins.
- R6: Trap `t` has vector number `t`, and maskable source `i` has vector number `N_TRAP+i`. With `alt_tbl` = 0 the entry address is `0x000004 + 2*vec_num`.
- R7: With `alt_tbl` = 1 the entry address is `0x000004 + 2*(N_TRAP+N_IRQ) + 2*vec_num`. With the defaults this is `0x000100 + 2*vec_num`.
- R8: Inputs sampled at clock edge k are reflected in `int_req`, `vec_num` and `vec_addr` right after edge k+1. A set pulse at edge k raises the request after edge k+1. `vec_num` and `vec_addr` read 0 whenever `int_req` is 0.
- R9: When `cpu_take` is high while `int_req` is high, `int_ack` is 1 for exactly the next cycle and the taken source's pending flag is cleared. `cpu_take` while `int_req` is low has no effect.
- R10: After a take, `int_req` stays 0 until an edge at which `cpu_return` is high. At that edge arbitration resumes, so a remaining request appears right after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alt_tbl | input | 1 | Selects the alternate vector table |
| trap_set | input | N_TRAP (8) | Per-trap set pulses |
| irq_set | input | N_IRQ (118) | Per-source set pulses for maskable interrupts |
| irq_en | input | N_IRQ (118) | Per-source enable |
| irq_lvl | input | 3*N_IRQ (354) | Packed 3-bit levels, source i in bits 3i+2..3i |
| cpu_lvl | input | 3 | Current CPU priority level |
| cpu_take | input | 1 | CPU takes the presented vector |
| cpu_return | input | 1 | CPU returns from the handler |
| int_req | output | 1 | Interrupt request to the CPU |
| vec_num | output | 8 | Vector number of the presented request |
| vec_addr | output | 24 | Program address of the vector-table entry |
| int_ack | output | 1 | One-cycle acknowledge after a take |

## Verification
A set pulse driven before edge k raises `int_req` right after edge k+1. A take at edge k shows `int_ack` right after edge k, with the request already dropped. A return at edge k lets the next winner appear right after that same edge. The bench drives inputs just after a falling edge and steps a behavioural model once per rising edge. It compares all four outputs just after the following falling edge, so every result is read in the cycle it is due. Directed checks first confirm the one-cycle gap between a set pulse and the request, then the values of the arbitration and address corner cases.

// File: rtl/prio_vic_pkg.sv
package prio_vic_pkg;

    localparam int LVL_W        = 3;
    localparam int VEC_W        = 8;
    localparam int ADDR_W       = 24;
    localparam int ENTRY_STRIDE = 2;
    localparam logic [ADDR_W-1:0] PRIMARY_BASE = 24'h000004;

    typedef logic [LVL_W-1:0]  level_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // result of a priority pick over one group of sources
    typedef struct packed {
        logic hit;
        vec_t idx;
    } pick_t;

    // registered request presented to the CPU
    typedef struct packed {
        logic  req;
        vec_t  vec;
        addr_t addr;
    } grant_t;

    // entry address: table base plus stride times vector number
    function automatic addr_t entry_addr(input logic alt, input vec_t vec, input int total);
        addr_t base;
        base = alt ? (PRIMARY_BASE + addr_t'(ENTRY_STRIDE * total)) : PRIMARY_BASE;
        return base + addr_t'(ENTRY_STRIDE) * addr_t'(vec);
    endfunction

endpackage

// File: rtl/prio_vic_flags.sv
module prio_vic_flags #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);

    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flag_o[g] <= 1'b0;
            end else if (set_i[g]) begin
                // a new event on the take edge is not lost
                flag_o[g] <= 1'b1;
            end else if (clr_i[g]) begin
                flag_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/prio_vic_first.sv
module prio_vic_first
    import prio_vic_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] pend_i,
    output pick_t        pick_o
);

    // lowest set index wins
    always_comb begin
        pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                pick_o.hit = 1'b1;
                pick_o.idx = vec_t'(i);
            end
        end
    end

endmodule

// File: rtl/prio_vic_rank.sv
module prio_vic_rank
    import prio_vic_pkg::*;
#(
    parameter int N = 118
) (
    input  logic [N-1:0]       pend_i,
    input  logic [N-1:0]       en_i,
    input  logic [N*LVL_W-1:0] lvl_i,
    input  level_t             cpu_lvl_i,
    output pick_t              pick_o
);

    level_t       lvl_a [N];
    logic [N-1:0] elig;

    for (genvar g = 0; g < N; g++) begin : g_src
        assign lvl_a[g] = lvl_i[g*LVL_W +: LVL_W];
        assign elig[g]  = pend_i[g] && en_i[g] && (lvl_a[g] != '0) && (lvl_a[g] > cpu_lvl_i);
    end

    // scan from the top so that a tie settles on the lower index
    always_comb begin
        level_t best;
        best   = '0;
        pick_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i] && (lvl_a[i] >= best)) begin
                best       = lvl_a[i];
                pick_o.hit = 1'b1;
                pick_o.idx = vec_t'(i);
            end
        end
    end

endmodule

// File: rtl/prio_vic.sv
module prio_vic
    import prio_vic_pkg::*;
#(
    parameter int N_TRAP = 8,
    parameter int N_IRQ  = 118
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alt_tbl,
    input  logic [N_TRAP-1:0]      trap_set,
    input  logic [N_IRQ-1:0]       irq_set,
    input  logic [N_IRQ-1:0]       irq_en,
    input  logic [N_IRQ*LVL_W-1:0] irq_lvl,
    input  logic [LVL_W-1:0]       cpu_lvl,
    input  logic                   cpu_take,
    input  logic                   cpu_return,
    output logic                   int_req,
    output logic [VEC_W-1:0]       vec_num,
    output logic [ADDR_W-1:0]      vec_addr,
    output logic                   int_ack
);

    localparam int N_VEC = N_TRAP + N_IRQ;

    logic [N_TRAP-1:0] trap_pend, trap_clr;
    logic [N_IRQ-1:0]  irq_pend, irq_clr;
    pick_t             trap_pick, irq_pick;
    grant_t            grant_q, grant_d;
    logic              busy_q, busy_d, ack_q;
    logic              take;

    assign take = cpu_take && grant_q.req;

    // clear strobes for the source being taken
    for (genvar t = 0; t < N_TRAP; t++) begin : g_tclr
        assign trap_clr[t] = take && (grant_q.vec == vec_t'(t));
    end
    for (genvar i = 0; i < N_IRQ; i++) begin : g_iclr
        assign irq_clr[i] = take && (grant_q.vec == vec_t'(N_TRAP + i));
    end

    prio_vic_flags #(.N(N_TRAP)) u_trap_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (trap_set),
        .clr_i  (trap_clr),
        .flag_o (trap_pend)
    );

    prio_vic_flags #(.N(N_IRQ)) u_irq_flags (
        .clk    (clk),
        .rst    (rst),
        .set_i  (irq_set),
        .clr_i  (irq_clr),
        .flag_o (irq_pend)
    );

    prio_vic_first #(.N(N_TRAP)) u_trap_pick (
        .pend_i (trap_pend),
        .pick_o (trap_pick)
    );

    prio_vic_rank #(.N(N_IRQ)) u_irq_rank (
        .pend_i    (irq_pend),
        .en_i      (irq_en),
        .lvl_i     (irq_lvl),
        .cpu_lvl_i (cpu_lvl),
        .pick_o    (irq_pick)
    );

    always_comb begin
        logic hit;
        vec_t sel;
        if (take) begin
            busy_d = 1'b1;
        end else if (cpu_return) begin
            busy_d = 1'b0;
        end else begin
            busy_d = busy_q;
        end

        hit = trap_pick.hit || irq_pick.hit;
        sel = trap_pick.hit ? trap_pick.idx : (irq_pick.idx + vec_t'(N_TRAP));

        grant_d = '0;
        if (hit && !busy_d) begin
            grant_d.req  = 1'b1;
            grant_d.vec  = sel;
            grant_d.addr = entry_addr(alt_tbl, sel, N_VEC);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            grant_q <= '0;
            busy_q  <= 1'b0;
            ack_q   <= 1'b0;
        end else begin
            grant_q <= grant_d;
            busy_q  <= busy_d;
            ack_q   <= take;
        end
    end

    assign int_req  = grant_q.req;
    assign vec_num  = grant_q.vec;
    assign vec_addr = grant_q.addr;
    assign int_ack  = ack_q;

endmodule

// File: rtl/prio_vic_chk.sv
module prio_vic_chk
    import prio_vic_pkg::*;
#(
    parameter int N_TRAP = 8,
    parameter int N_IRQ  = 118
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   alt_tbl,
    input logic [N_IRQ*LVL_W-1:0] irq_lvl,
    input logic [LVL_W-1:0]       cpu_lvl,
    input logic                   cpu_take,
    input logic                   int_req,
    input logic [VEC_W-1:0]       vec_num,
    input logic [ADDR_W-1:0]      vec_addr,
    input logic                   int_ack
);

    localparam int N_VEC = N_TRAP + N_IRQ;
    localparam logic [ADDR_W-1:0] ALT_BASE = 24'h000004 + ADDR_W'(2 * N_VEC);

    function automatic level_t lvl_of(input logic [N_IRQ*LVL_W-1:0] v, input int idx);
        return v[idx*LVL_W +: LVL_W];
    endfunction

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!int_req && !int_ack && vec_num == '0 && vec_addr == '0)); // R1

    AST_LEVEL_ABOVE_CPU: assert property (@(posedge clk) disable iff (rst)
        (int_req && vec_num >= VEC_W'(N_TRAP) && vec_num < VEC_W'(N_VEC)) |->
        (lvl_of($past(irq_lvl), int'(vec_num) - N_TRAP) > $past(cpu_lvl))); // R3

    AST_PRIMARY_ADDR: assert property (@(posedge clk) disable iff (rst)
        (int_req && !$past(alt_tbl)) |->
        (vec_addr == 24'h000004 + 24'(2) * 24'(vec_num))); // R6

    AST_ALT_ADDR: assert property (@(posedge clk) disable iff (rst)
        (int_req && $past(alt_tbl)) |->
        (vec_addr == ALT_BASE + 24'(2) * 24'(vec_num))); // R7

    AST_ACK_FOLLOWS_TAKE: assert property (@(posedge clk) disable iff (rst)
        (cpu_take && int_req) |=> (int_ack && !int_req)); // R9

    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        int_ack |=> !int_ack); // R9

    AST_NO_REQ_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
        int_ack |-> !int_req); // R10

endmodule

bind prio_vic prio_vic_chk #(.N_TRAP(N_TRAP), .N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/sim_prio_vic.sv
`timescale 1ns/1ps
module sim_prio_vic;

    localparam int NT = 8;
    localparam int NI = 118;
    localparam int NV = NT + NI;

    logic            clk = 1'b0;
    logic            rst;
    logic            alt_tbl;
    logic [NT-1:0]   trap_set;
    logic [NI-1:0]   irq_set, irq_en;
    logic [NI*3-1:0] irq_lvl;
    logic [2:0]      cpu_lvl;
    logic            cpu_take, cpu_return;
    logic            int_req, int_ack;
    logic [7:0]      vec_num;
    logic [23:0]     vec_addr;

    always #5 clk = ~clk;

    prio_vic #(.N_TRAP(NT), .N_IRQ(NI)) u0 (.*);

    // behavioural reference state
    bit m_tp [NT];
    bit m_ip [NI];
    bit m_busy, m_req, m_ack;
    int m_vec, m_addr;
    bit n_tp [NT];
    bit n_ip [NI];
    bit n_busy, n_req, n_ack;
    int n_vec, n_addr;

    int    checks = 0;
    int    misses = 0;
    string cur_tag = "R1";
    bit    done = 1'b0;

    task automatic model_next();
        bit take, hit;
        int v, best, lv, base;
        if (rst) begin
            foreach (n_tp[t]) n_tp[t] = 0;
            foreach (n_ip[i]) n_ip[i] = 0;
            n_busy = 0; n_req = 0; n_ack = 0; n_vec = 0; n_addr = 0;
            return;
        end
        take   = cpu_take && m_req;
        n_busy = take ? 1'b1 : (cpu_return ? 1'b0 : m_busy);
        hit = 0; v = 0; best = 0;
        for (int t = 0; t < NT; t++)
            if (!hit && m_tp[t]) begin hit = 1; v = t; end
        if (!hit) begin
            for (int i = 0; i < NI; i++) begin
                lv = int'(irq_lvl[3*i +: 3]);
                if (m_ip[i] && irq_en[i] && lv != 0 && lv > int'(cpu_lvl) && lv > best) begin
                    best = lv; v = NT + i; hit = 1;
                end
            end
        end
        base   = alt_tbl ? 4 + 2 * NV : 4;
        n_req  = hit && !n_busy;
        n_vec  = n_req ? v : 0;
        n_addr = n_req ? base + 2 * v : 0;
        n_ack  = take;
        for (int t = 0; t < NT; t++)
            n_tp[t] = trap_set[t] || (m_tp[t] && !(take && m_vec == t));
        for (int i = 0; i < NI; i++)
            n_ip[i] = irq_set[i] || (m_ip[i] && !(take && m_vec == NT + i));
    endtask

    task automatic compare();
        checks++;
        if (int_req !== m_req || int_ack !== m_ack ||
            int'(vec_num) != m_vec || int'(vec_addr) != m_addr) begin
            misses++;
            $display("FAIL %s: req/ack/vec/addr actual %0b/%0b/%0d/%0h expected %0b/%0b/%0d/%0h",
                     cur_tag, int_req, int_ack, vec_num, vec_addr, m_req, m_ack, m_vec, m_addr);
        end
    endtask

    task automatic tick();
        model_next();
        @(posedge clk);
        m_tp = n_tp; m_ip = n_ip;
        m_busy = n_busy; m_req = n_req; m_ack = n_ack; m_vec = n_vec; m_addr = n_addr;
        @(negedge clk);
        compare();
        trap_set = '0;
        irq_set  = '0;
    endtask

    // directed check against a value computed from the requirements
    task automatic expect_out(string tag, bit req, int vec, int addr, bit ack);
        checks++;
        if (int_req !== req || int'(vec_num) != vec || int'(vec_addr) != addr || int_ack !== ack) begin
            misses++;
            $display("FAIL %s: req/vec/addr/ack actual %0b/%0d/%0h/%0b expected %0b/%0d/%0h/%0b",
                     tag, int_req, vec_num, vec_addr, int_ack, req, vec, addr, ack);
        end
    endtask

    task automatic set_src(int i, int lvl);
        irq_lvl[3*i +: 3] = 3'(lvl);
        irq_en[i]  = 1'b1;
        irq_set[i] = 1'b1;
    endtask

    task automatic serve();
        cpu_take = 1'b1; tick(); cpu_take = 1'b0;
        cpu_return = 1'b1; tick(); cpu_return = 1'b0;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; alt_tbl = 0; trap_set = '0; irq_set = '0; irq_en = '0;
        irq_lvl = '0; cpu_lvl = 0; cpu_take = 0; cpu_return = 0;
        foreach (m_tp[t]) m_tp[t] = 0;
        foreach (m_ip[i]) m_ip[i] = 0;
        m_busy = 0; m_req = 0; m_ack = 0; m_vec = 0; m_addr = 0;

        // R1: reset state
        cur_tag = "R1";
        tick(); tick();
        rst = 1'b0;
        tick();
        expect_out("R1", 0, 0, 0, 0);

        // R8 and R6: one edge to capture, one edge to present
        cur_tag = "R8";
        set_src(5, 4);
        tick();
        expect_out("R8", 0, 0, 0, 0);
        tick();
        expect_out("R6", 1, 13, 4 + 26, 0);

        // R9 and R10: take, acknowledge, hold-off, return
        cur_tag = "R9";
        cpu_take = 1'b1; tick(); cpu_take = 1'b0;
        expect_out("R9", 0, 0, 0, 1);
        tick();
        expect_out("R10", 0, 0, 0, 0);
        cpu_return = 1'b1; tick(); cpu_return = 1'b0;
        expect_out("R2", 0, 0, 0, 0);

        // R4: level first, then lower index
        cur_tag = "R4";
        set_src(10, 3); set_src(20, 6); set_src(30, 6);
        tick(); tick();
        expect_out("R4", 1, NT + 20, 4 + 2 * (NT + 20), 0);
        serve();
        expect_out("R4", 1, NT + 30, 4 + 2 * (NT + 30), 0);
        serve();
        expect_out("R4", 1, NT + 10, 4 + 2 * (NT + 10), 0);
        serve();
        expect_out("R10", 0, 0, 0, 0);

        // R3: eligibility against cpu level, enable and level zero
        cur_tag = "R3";
        cpu_lvl = 2;
        set_src(40, 2);
        tick(); tick();
        expect_out("R3", 0, 0, 0, 0);
        cpu_lvl = 1; tick();
        expect_out("R3", 1, NT + 40, 4 + 2 * (NT + 40), 0);
        cpu_lvl = 0; irq_en[40] = 1'b0; tick();
        expect_out("R3", 0, 0, 0, 0);
        irq_en[40] = 1'b1; irq_lvl[3*40 +: 3] = 3'd0; tick();
        expect_out("R3", 0, 0, 0, 0);
        irq_lvl[3*40 +: 3] = 3'd5; tick();
        expect_out("R2", 1, NT + 40, 4 + 2 * (NT + 40), 0);
        serve();

        // R5: traps above everything, lowest trap first
        cur_tag = "R5";
        cpu_lvl = 7;
        set_src(50, 7);
        trap_set[3] = 1'b1; trap_set[1] = 1'b1;
        tick(); tick();
        expect_out("R5", 1, 1, 6, 0);
        serve();
        expect_out("R5", 1, 3, 10, 0);
        serve();
        expect_out("R5", 0, 0, 0, 0);
        cpu_lvl = 6; tick();
        expect_out("R5", 1, NT + 50, 4 + 2 * (NT + 50), 0);
        serve();
        cpu_lvl = 0;

        // R7: alternate table
        cur_tag = "R7";
        alt_tbl = 1'b1;
        trap_set[0] = 1'b1;
        set_src(117, 1);
        tick(); tick();
        expect_out("R7", 1, 0, 24'h100, 0);
        serve();
        expect_out("R7", 1, NT + 117, 24'h100 + 2 * (NT + 117), 0);
        serve();
        alt_tbl = 1'b0;

        // R9 ignore: take with no request; R2 set on the take edge
        cur_tag = "R9";
        cpu_take = 1'b1; tick(); cpu_take = 1'b0;
        expect_out("R9", 0, 0, 0, 0);
        set_src(7, 2);
        tick(); tick();
        cpu_take = 1'b1; irq_set[7] = 1'b1; tick(); cpu_take = 1'b0;
        expect_out("R9", 0, 0, 0, 1);
        cpu_return = 1'b1; tick(); cpu_return = 1'b0;
        expect_out("R2", 1, NT + 7, 4 + 2 * (NT + 7), 0);
        serve();

        // random traffic, compared against the model every cycle (R8)
        cur_tag = "R8";
        for (int c = 0; c < 3000; c++) begin
            for (int i = 0; i < NI; i++) begin
                if ($urandom_range(63) == 0) irq_set[i] = 1'b1;
                if ($urandom_range(31) == 0) irq_en[i] = 1'($urandom_range(1));
                if ($urandom_range(63) == 0) irq_lvl[3*i +: 3] = 3'($urandom_range(7));
            end
            for (int t = 0; t < NT; t++)
                if ($urandom_range(511) == 0) trap_set[t] = 1'b1;
            if ($urandom_range(15) == 0) cpu_lvl = 3'($urandom_range(7));
            if ($urandom_range(63) == 0) alt_tbl = ~alt_tbl;
            cpu_take   = ($urandom_range(2) == 0);
            cpu_return = ($urandom_range(3) == 0);
            tick();
        end
        cpu_take = 0; cpu_return = 0;

        // R1: reset in the middle of traffic
        cur_tag = "R1";
        rst = 1'b1; tick(); rst = 1'b0; tick();
        expect_out("R1", 0, 0, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, misses);
        $finish;
    end

endmodule